// File: doc/BRIEF.md
# Hardware Lock Register Bank

This block is a set of hardware mutex bits that several bus masters share. It sits behind a simple single-cycle slave port. Each lock has its own word-aligned register. A read of that register is an atomic test-and-set. Bit 0 of the read data tells the reader whether it now owns the lock. A write of 1 to the same register frees the lock again.

A separate read-only status word shows every lock bit at once. Software can use it to see which resources are taken without changing any lock. A master that reads 0 from a lock register did not get it and polls again later. The block records no owner, so releasing a lock is left to the software that holds it.

Top module: `hw_lock_bank`

## Requirements
- R1: After reset every lock is free, and the status word reads 0.
- R2: Lock i is decoded at word address i (byte offset i*4) for i from 0 to NUM_LOCKS-1 (default 15). The status word is at word address STATUS_WORD (default 16, byte offset 0x40).
- R3: A read of a free lock returns rdata = 1 in the acknowledged cycle and sets that lock in the same clock edge.
- R4: A read of a held lock returns rdata = 0 and leaves the lock set. In any lock read, bits 31:1 are 0.
- R5: A write whose bit 0 is 1 to a lock register clears that lock. A write whose bit 0 is 0 to a lock register has no effect.
- R6: Bit i of the status word equals lock i. Bits at or above NUM_LOCKS read 0. With all locks held it reads 0x7FFF.
- R7: Any access to one lock leaves every other lock bit unchanged. Writes to the status word have no effect.
- R8: Every request (req = 1) is acknowledged on the next clock edge. Reads of unmapped addresses return 0.
- R9: Two back-to-back reads of the same free lock give 1 to the first reader and 0 to the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address within the block |
| wdata | input | 32 | Write data |
| ack | output | 1 | Access acknowledge, one cycle after req |
| rdata | output | 32 | Read data, valid with ack |

## Verification
The bench targets the race between back-to-back reads of one lock. A design that samples the lock state before the previous set has landed would hand the lock to both readers. It also checks that a write of 0 and a write to the status word leave the locks unchanged. A design that decodes any write as a release would free a lock at random. Status packing is checked one lock at a time and with all locks held. A design with a shifted index or a bit leaking across locks would read the wrong value.

// File: rtl/hw_lock_pkg.sv
package hw_lock_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_LOCK   = 2'd1,
    SEL_STATUS = 2'd2
  } sel_kind_e;

  typedef struct packed {
    sel_kind_e  kind;
    logic [5:0] idx;
  } sel_t;
endpackage

// File: rtl/hw_lock_decode.sv
module hw_lock_decode
  import hw_lock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS   = 15,
  parameter int unsigned STATUS_WORD = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;

  always_comb begin
    word     = addr[ADDR_W-1:2];
    sel.kind = SEL_NONE;
    sel.idx  = '0;
    if (32'(word) < NUM_LOCKS) begin
      sel.kind = SEL_LOCK;
      sel.idx  = 6'(word);
    end else if (32'(word) == STATUS_WORD) begin
      sel.kind = SEL_STATUS;
    end
  end
endmodule

// File: rtl/hw_lock_cell.sv
module hw_lock_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic acquire,
  input  logic release_i,
  output logic held
);
  logic held_nxt;

  always_comb begin
    held_nxt = held;
    if (acquire)        held_nxt = 1'b1;
    else if (release_i) held_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   held <= 1'b0;
    else if (acquire | release_i) held <= held_nxt;
  end

  p_no_dual_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acquire && release_i));
  p_set_on_acquire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acquire |=> held);
  p_clear_on_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> !held);
  p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acquire || release_i) |=> $stable(held));
endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank
  import hw_lock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS   = 15,
  parameter int unsigned STATUS_WORD = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);
  sel_t                 sel;
  logic [NUM_LOCKS-1:0] locks;
  logic [NUM_LOCKS-1:0] acq_vec;
  logic [NUM_LOCKS-1:0] rel_vec;
  logic [DATA_W-1:0]    rdata_nxt;
  logic                 rd_en;

  hw_lock_decode #(.NUM_LOCKS(NUM_LOCKS), .STATUS_WORD(STATUS_WORD)) i_dec (
    .addr (addr),
    .sel  (sel)
  );

  generate
    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
      assign acq_vec[g] = req && !we && sel.kind == SEL_LOCK
                          && 32'(sel.idx) == g && !locks[g];
      assign rel_vec[g] = req && we && wdata[0] && sel.kind == SEL_LOCK
                          && 32'(sel.idx) == g;
      hw_lock_cell i_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .acquire   (acq_vec[g]),
        .release_i (rel_vec[g]),
        .held      (locks[g])
      );
    end
  endgenerate

  assign rd_en = req && !we;

  always_comb begin
    rdata_nxt = '0;
    if (rd_en) begin
      case (sel.kind)
        SEL_LOCK:   rdata_nxt[0] = !locks[sel.idx];
        SEL_STATUS: rdata_nxt[NUM_LOCKS-1:0] = locks;
        default:    rdata_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= req;
      if (rd_en) rdata <= rdata_nxt;
    end
  end

  p_ack_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ack);
  p_no_spurious_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !ack);
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel.kind == SEL_LOCK) |=> rdata[DATA_W-1:1] == '0);
  p_win_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel.kind == SEL_LOCK) |=> locks[$past(sel.idx)]);
  p_single_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(acq_vec | rel_vec) <= 1);
endmodule

// File: tb/test_hw_lock_bank.sv
module test_hw_lock_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic        ack;
  logic [31:0] rdata;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  hw_lock_bank i_hw_lock_bank (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata)
  );

  localparam logic [7:0] STAT = 8'h40;

  // vector: we, addr, wdata, expected rdata (reads only)
  typedef struct packed {
    logic        w;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;
  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{1'b0, 8'h00, 32'h0, 32'h1},      // R3 acquire lock0
    '{1'b0, 8'h00, 32'h0, 32'h0},      // R4 held
    '{1'b0, STAT,  32'h0, 32'h1},      // R6
    '{1'b0, 8'h38, 32'h0, 32'h1},      // R2 lock14
    '{1'b0, STAT,  32'h0, 32'h4001},   // R6/R7
    '{1'b1, 8'h00, 32'h0, 32'h0},      // R5 write 0 no effect
    '{1'b0, STAT,  32'h0, 32'h4001},   // R5
    '{1'b1, STAT,  32'h0, 32'h0},      // R7 status write ignored
    '{1'b0, STAT,  32'h0, 32'h4001},   // R7
    '{1'b1, 8'h00, 32'h1, 32'h0},      // R5 release lock0
    '{1'b0, STAT,  32'h0, 32'h4000},   // R5/R7
    '{1'b0, 8'h3C, 32'h0, 32'h0}       // R8 unmapped
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one access; samples on the falling edge after the acknowledge edge
  task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic ak);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    rd = rdata; ak = ack;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, rd2;
    logic        ak;
    logic [31:0] exp;
    req = 0; we = 0; addr = 0; wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    access(0, STAT, 0, rd, ak);
    check("R1 status after reset", rd, 32'h0);
    check("R8 ack", {31'b0, ak}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      access(VT[i].w, VT[i].a, VT[i].d, rd, ak);
      if (!VT[i].w) check($sformatf("R3/R4/R5/R6/R7 vector %0d", i), rd, VT[i].e);
    end

    // R9 back-to-back reads of lock 5
    @(negedge clk);
    req = 1; we = 0; addr = 8'h14;
    @(negedge clk);
    rd = rdata;
    @(negedge clk);
    req = 0;
    rd2 = rdata;
    check("R9 first reader wins", rd, 32'h1);
    check("R9 second reader loses", rd2, 32'h0);

    // R6 fill all, with status tracking
    exp = 32'h4020;
    for (int i = 0; i < 15; i++) begin
      access(0, 8'(i*4), 0, rd, ak);
      exp |= (32'h1 << i);
    end
    access(0, STAT, 0, rd, ak);
    check("R6 all held", rd, 32'h7FFF);
    for (int i = 0; i < 15; i++) begin
      access(1, 8'(i*4), 32'h1, rd, ak);
      exp ^= (32'h1 << i);
      access(0, STAT, 0, rd, ak);
      check($sformatf("R7 release lock %0d", i), rd, exp);
    end

    // R1 reset mid-use
    access(0, 8'h08, 0, rd, ak);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    access(0, STAT, 0, rd, ak);
    check("R1 reset clears locks", rd, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule